// File: doc/BRIEF.md
# Infrared Pulse-Timing Capture Receiver

This block watches the output of a demodulated infrared or UHF receiver and measures every symbol of an incoming pulse train in sample ticks. For each symbol it records how long the carrier was present (the mark) and how long it was from that mark's leading edge to the next leading edge (the whole symbol period). The space is the period minus the mark. Each measured pair goes into a small FIFO that a host drains through a word-addressed register interface.

A programmable prescaler sets the sample tick; a nominal setup aims at a 10 MHz tick, so the divisor is the system clock frequency over 10 MHz. A polarity control lets an active-low pin be used directly. A programmable glitch filter removes short input spikes before any edge is seen. When no new mark arrives within a programmable maximum period, the last symbol of the train is stored with the period code all ones and a dedicated interrupt source fires. Four interrupt sources share one bit layout for enable, status and clear.

Register map (byte offsets): 0x00 head mark, 0x04 head period (reading pops), 0x08 interrupt enable, 0x0C interrupt status, 0x10 receive enable (bit 0), 0x14 maximum period, 0x18 interrupt clear, 0x1C minimum pulse width, 0x20 tick divisor, 0x28 polarity invert (bit 0), 0x2C status.

Top module: `ir_capture_rx`

## Requirements
- R1: The sample tick occurs once every N system clocks, N being the divisor register (0x20), with 0 acting as 1; all durations are counted in these ticks.
- R2: A symbol whose mark lasts M ticks and whose next leading edge comes P ticks after its own leading edge is stored as mark M (register 0x00) and period P (register 0x04).
- R3: If no leading edge arrives within the maximum period (0x14, in ticks) after a leading edge, the symbol is stored with period 0xFFFF and interrupt status bit 1 is set.
- R4: With bit 0 of the invert register (0x28) set, a low pin is a mark; with it clear, a high pin is a mark.
- R5: An input excursion shorter than the minimum pulse width (0x1C, in ticks) is ignored and leaves the stored mark and period unchanged.
- R6: Register 0x00 shows the oldest entry's mark; a read of 0x04 returns its period and removes it; reads of either on an empty FIFO return 0 and remove nothing.
- R7: A new entry arriving at a full FIFO is discarded, the older entries are kept, and the overrun flag (interrupt status bit 2, status bit 2) stays set until written with 1 at bit 2 of 0x18.
- R8: Status register (0x2C) bits 15:8 hold the number of stored entries.
- R9: Interrupt status bit 0 is set by every stored entry and bit 3 when the FIFO becomes full; a 1 written to a bit of 0x18 clears that status bit; the irq output is high exactly when a status bit and its enable bit (0x08) are both set.
- R10: While receive enable (0x10 bit 0) is 0, no entry is stored and no interrupt status bit is set by the input.
- R11: After reset the status, interrupt status and head mark read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_pin | input | 1 | Demodulated receiver output, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on period read) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions watch, on every cycle, that ticks stay spaced by the divisor, that a stored mark never exceeds its period, that the FIFO fill never passes its depth and drops by one on each pop, and that the overrun flag only falls on an explicit clear. Whether the measured values match the durations actually driven, that the polarity and glitch settings act as intended, that the timeout code appears at the end of a train, and that a disabled receiver stores nothing, can only be shown by the bench's pulse trains compared against its scoreboard.

// File: rtl/ir_capture_pkg.sv
// Package: shared widths, entry layout and register offsets of the capture receiver.
// Assumes: byte-addressed 32-bit registers in a 64-byte window.
package ir_capture_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 6;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] mark;
    } ir_entry_t;

    localparam logic [ADDR_W-1:0] A_MARK   = 6'h00;
    localparam logic [ADDR_W-1:0] A_PERIOD = 6'h04;
    localparam logic [ADDR_W-1:0] A_IEN    = 6'h08;
    localparam logic [ADDR_W-1:0] A_ISTAT  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_RXEN   = 6'h10;
    localparam logic [ADDR_W-1:0] A_MAXPER = 6'h14;
    localparam logic [ADDR_W-1:0] A_ICLR   = 6'h18;
    localparam logic [ADDR_W-1:0] A_MINW   = 6'h1C;
    localparam logic [ADDR_W-1:0] A_DIV    = 6'h20;
    localparam logic [ADDR_W-1:0] A_INV    = 6'h28;
    localparam logic [ADDR_W-1:0] A_STAT   = 6'h2C;
endpackage

// File: rtl/ir_sampler.sv
// Sampler: divides the clock down to a sample tick, synchronises and
// optionally inverts the pin, and filters out pulses narrower than minw_i.
// Assumes: pin is asynchronous; minw_i of 0 or 1 means no filtering.
module ir_sampler #(
    parameter int DIV_W = 8,
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             invert_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [FLT_W-1:0] minw_i,
    output logic             tick_o,
    output logic             level_o
);
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] div_eff;
    logic             sync1, sync2, samp;
    logic [FLT_W-1:0] run;

    // Effective divisor and tick decode.
    always_comb begin
        div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
        tick_o  = (pcnt >= div_eff - DIV_W'(1));
        samp    = sync2 ^ invert_i;
    end

    // Prescaler counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (tick_o) pcnt <= '0;
        else             pcnt <= pcnt + DIV_W'(1);
    end

    // Two-flop synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= pin_i;
            sync2 <= sync1;
        end
    end

    // Width filter: the level follows only after minw_i differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= 1'b0;
            run     <= '0;
        end else if (tick_o) begin
            if (samp == level_o) begin
                run <= '0;
            end else if ({1'b0, run} + (FLT_W+1)'(1) >= {1'b0, minw_i}) begin
                level_o <= samp;
                run     <= '0;
            end else begin
                run <= run + FLT_W'(1);
            end
        end
    end

    // R1: with an unchanged divisor above 1, ticks never come back to back.
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_eff > DIV_W'(1)) |=> (!tick_o || div_i != $past(div_i)));
endmodule

// File: rtl/ir_timer.sv
// Timer: measures mark length and leading-edge-to-leading-edge period in
// ticks and produces one entry per symbol; ends a train on timeout.
// Assumes: level_i is already filtered; counters saturate at all ones.
module ir_timer
    import ir_capture_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             level_i,
    input  logic [CNT_W-1:0] maxper_i,
    output logic             push_o,
    output logic             timeout_o,
    output ir_entry_t        entry_o
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic             prev, active, in_mark;
    logic [CNT_W-1:0] mark_cnt, per_cnt;
    logic             rise, tmo;

    // Edge, timeout and entry formation.
    always_comb begin
        rise      = tick_i && level_i && !prev;
        tmo       = tick_i && active && !level_i && (per_cnt >= maxper_i);
        push_o    = en_i && ((rise && active) || tmo);
        timeout_o = en_i && tmo;
        entry_o.mark   = mark_cnt;
        entry_o.period = tmo ? SAT : per_cnt;
    end

    // Symbol state and saturating duration counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev     <= 1'b0;
            active   <= 1'b0;
            in_mark  <= 1'b0;
            mark_cnt <= '0;
            per_cnt  <= '0;
        end else begin
            if (tick_i) prev <= level_i;
            if (!en_i) begin
                active  <= 1'b0;
                in_mark <= 1'b0;
            end else if (tick_i) begin
                if (rise) begin
                    active   <= 1'b1;
                    in_mark  <= 1'b1;
                    mark_cnt <= CNT_W'(1);
                    per_cnt  <= CNT_W'(1);
                end else if (tmo) begin
                    active  <= 1'b0;
                    in_mark <= 1'b0;
                end else if (active) begin
                    if (per_cnt != SAT) per_cnt <= per_cnt + CNT_W'(1);
                    if (in_mark && level_i && mark_cnt != SAT)
                        mark_cnt <= mark_cnt + CNT_W'(1);
                    if (!level_i) in_mark <= 1'b0;
                end
            end
        end
    end

    // R2: a completed symbol never has a mark longer than its period.
    assert_mark_within_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && entry_o.period != SAT) |-> (entry_o.mark <= entry_o.period));
endmodule

// File: rtl/ir_fifo.sv
// FIFO: stores measured entries; a push into a full FIFO is refused.
// Assumes: DEPTH is a power of two; the full check ignores a same-cycle pop.
module ir_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       pop_i,
    output logic [W-1:0]               head_o,
    output logic [$clog2(DEPTH):0]     count_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic                       accept_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_pop;

    // Flags and handshakes.
    always_comb begin
        empty_o  = (count_o == '0);
        full_o   = (count_o == (AW+1)'(DEPTH));
        accept_o = push_i && !full_o;
        do_pop   = pop_i && !empty_o;
        head_o   = mem[rptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (accept_o) mem[wptr] <= wdata_i;
    end

    // Pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count_o <= '0;
        end else begin
            if (accept_o) wptr <= wptr + AW'(1);
            if (do_pop)   rptr <= rptr + AW'(1);
            count_o <= count_o + (AW+1)'(accept_o) - (AW+1)'(do_pop);
        end
    end

    // R7: fill never exceeds the depth.
    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= (AW+1)'(DEPTH));
    // R6: a pop of a non-empty FIFO without a push lowers the fill by one.
    assert_pop_drops_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o && !push_i) |=> (count_o == $past(count_o) - (AW+1)'(1)));
endmodule

// File: rtl/ir_capture_rx.sv
// Top: register file, interrupt logic and wiring of sampler, timer and FIFO.
// Assumes: reads have no side effect except a read of the period register.
module ir_capture_rx
    import ir_capture_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DIV_W = 8,
    parameter int FLT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_pin,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [3:0]       ien, istat, clr, set;
    logic             rxen, inv;
    logic [CNT_W-1:0] maxper;
    logic [FLT_W-1:0] minw;
    logic [DIV_W-1:0] div;
    logic             tick, level, push, tmo, accept, pop, empty, full;
    ir_entry_t        entry, head;
    logic [CW-1:0]    count;

    ir_sampler #(.DIV_W(DIV_W), .FLT_W(FLT_W)) sampler_i (
        .clk(clk), .rst_n(rst_n), .pin_i(ir_pin), .invert_i(inv),
        .div_i(div), .minw_i(minw), .tick_o(tick), .level_o(level));

    ir_timer timer_i (
        .clk(clk), .rst_n(rst_n), .en_i(rxen), .tick_i(tick), .level_i(level),
        .maxper_i(maxper), .push_o(push), .timeout_o(tmo), .entry_o(entry));

    ir_fifo #(.DEPTH(DEPTH), .W($bits(ir_entry_t))) fifo_i (
        .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(entry), .pop_i(pop),
        .head_o(head), .count_o(count), .empty_o(empty), .full_o(full),
        .accept_o(accept));

    // Pop strobe, interrupt set/clear masks and request.
    always_comb begin
        pop    = reg_rd && (reg_addr == A_PERIOD);
        clr    = (reg_wr && reg_addr == A_ICLR) ? reg_wdata[3:0] : 4'h0;
        set[0] = accept;
        set[1] = tmo;
        set[2] = push && full;
        set[3] = accept && !(pop && !empty) && (count == CW'(DEPTH - 1));
        irq    = |(istat & ien);
    end

    // Control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien    <= '0;
            rxen   <= 1'b0;
            inv    <= 1'b0;
            maxper <= '1;
            minw   <= '0;
            div    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_IEN:    ien    <= reg_wdata[3:0];
                A_RXEN:   rxen   <= reg_wdata[0];
                A_INV:    inv    <= reg_wdata[0];
                A_MAXPER: maxper <= reg_wdata[CNT_W-1:0];
                A_MINW:   minw   <= reg_wdata[FLT_W-1:0];
                A_DIV:    div    <= reg_wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    // Sticky interrupt status; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) istat <= '0;
        else        istat <= (istat & ~clr) | set;
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MARK:   reg_rdata = empty ? 32'h0 : 32'(head.mark);
            A_PERIOD: reg_rdata = empty ? 32'h0 : 32'(head.period);
            A_IEN:    reg_rdata = 32'(ien);
            A_ISTAT:  reg_rdata = 32'(istat);
            A_RXEN:   reg_rdata = 32'(rxen);
            A_MAXPER: reg_rdata = 32'(maxper);
            A_MINW:   reg_rdata = 32'(minw);
            A_DIV:    reg_rdata = 32'(div);
            A_INV:    reg_rdata = 32'(inv);
            A_STAT:   reg_rdata = {16'h0, 8'(count), 5'h0, istat[2], 2'h0};
            default:  reg_rdata = '0;
        endcase
    end

    // R7: overrun flag only falls through an explicit clear.
    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(istat[2]) && !$past(clr[2])) |-> istat[2]);
    // R10: with receive disabled nothing reaches the FIFO.
    assert_no_store_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxen && !pop) |=> (count == $past(count)));
endmodule

// File: tb/ir_capture_rx_tb_top.sv
`timescale 1ns/1ps
module ir_capture_rx_tb_top;
    import ir_capture_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_pin = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq;

    int checks = 0, errors = 0;
    int clk_per_tick = 4;
    logic act_lvl = 1'b0;
    logic [31:0] exp_q[$];
    bit done = 0;

    ir_capture_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ir_pin(ir_pin), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic hold(input bit mark, input int ticks);
        @(negedge clk);
        ir_pin = mark ? act_lvl : ~act_lvl;
        repeat (ticks * clk_per_tick - 1) @(negedge clk);
    endtask

    // Driver: one symbol followed by the next leading edge.
    task automatic sym(input int m, input int s);
        hold(1, m); hold(0, s);
        exp_q.push_back({16'(m + s), 16'(m)});
    endtask

    // Driver: last symbol of a train, ended by timeout.
    task automatic last_sym(input int m);
        hold(1, m); hold(0, 150);
        exp_q.push_back({16'hFFFF, 16'(m)});
    endtask

    // Monitor: drain the FIFO and compare against the scoreboard.
    task automatic monitor(input string req);
        logic [31:0] st, mk, pr, e;
        rd(A_STAT, st);
        for (int i = 0; i < int'(st[15:8]); i++) begin
            rd(A_MARK, mk);
            rd(A_PERIOD, pr);
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_DEAD;
            check(req, {pr[15:0], mk[15:0]}, e);
        end
        check({req, " scoreboard empty"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        rd(A_STAT, d);  check("R11 status", d, 32'h0);
        rd(A_ISTAT, d); check("R11 istat", d, 32'h0);
        rd(A_MARK, d);  check("R11 mark", d, 32'h0);
        check("R11 irq", 32'(irq), 32'h0);

        // R2 R4: active-low pin with inversion, divisor 4
        wr(A_DIV, 4); wr(A_MAXPER, 100); wr(A_INV, 1); wr(A_IEN, 0);
        hold(0, 10);
        wr(A_RXEN, 1);
        sym(10, 20); sym(5, 7); last_sym(8);
        rd(A_ISTAT, d); check("R3 R9 istat avail+last", d, 32'h3);
        check("R9 irq masked", 32'(irq), 32'h0);
        wr(A_IEN, 2); #1 check("R9 irq enabled", 32'(irq), 32'h1);
        wr(A_ICLR, 2); #1 check("R9 irq cleared", 32'(irq), 32'h0);
        rd(A_STAT, d); check("R8 fill count", d, 32'h300);
        monitor("R2 R3 R6 inverted train");

        // R4: active-high pin without inversion
        wr(A_RXEN, 0); wr(A_INV, 0); act_lvl = 1'b1; hold(0, 10); wr(A_RXEN, 1);
        sym(6, 6); last_sym(4);
        monitor("R4 non-inverted train");

        // R5: glitch narrower than the minimum width
        wr(A_MINW, 3);
        hold(1, 10); hold(0, 8); hold(1, 1); hold(0, 11);
        exp_q.push_back({16'd30, 16'd10});
        last_sym(7);
        monitor("R5 glitch ignored");

        // R1: divisor 2
        wr(A_RXEN, 0); wr(A_DIV, 2); clk_per_tick = 2; hold(0, 10); wr(A_RXEN, 1);
        sym(9, 3); last_sym(5);
        monitor("R1 divisor 2");

        // R7 R8 R9: overrun with depth 4
        wr(A_ICLR, 32'hF);
        sym(4, 4); sym(4, 4); sym(4, 4); sym(4, 4);
        hold(1, 4); hold(0, 150);
        rd(A_ISTAT, d); check("R7 R9 istat all", d, 32'hF);
        rd(A_STAT, d);  check("R7 R8 status full+ovf", d, 32'h404);
        wr(A_IEN, 4); #1 check("R7 irq overrun", 32'(irq), 32'h1);
        wr(A_ICLR, 4); #1 check("R7 irq after clear", 32'(irq), 32'h0);
        rd(A_ISTAT, d); check("R7 istat after clear", d, 32'hB);
        rd(A_STAT, d);  check("R7 status after clear", d, 32'h400);
        monitor("R7 kept entries");

        // R10: receive disabled
        wr(A_ICLR, 32'hF); wr(A_RXEN, 0);
        hold(1, 5); hold(0, 5); hold(1, 5); hold(0, 150);
        rd(A_STAT, d);  check("R10 nothing stored", d, 32'h0);
        rd(A_ISTAT, d); check("R10 no status", d, 32'h0);

        // R6: reads on an empty FIFO
        rd(A_PERIOD, d); check("R6 empty period", d, 32'h0);
        rd(A_MARK, d);   check("R6 empty mark", d, 32'h0);
        rd(A_STAT, d);   check("R6 empty unchanged", d, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule